// File: doc/BRIEF.md
# Offload-Pausing Schedule Counter

This block sequences a parent schedule of fixed latency that hands control to child schedules during given cycle windows. The windows are set by parameters as a sorted list of non-overlapping start/end cycle pairs. Outside the windows the counter moves through "normal" states, one per cycle. Each window becomes a single "offload" state. The counter stays in that state while the child runs and moves on only when that child reports completion. The number of states is therefore the count of gap cycles plus one per child, not the full latency.

A start pulse launches the schedule from state 0. The whole schedule then runs a parameterised number of passes back to back, and a one-cycle completion pulse follows the final state of the last pass. The state register holds either a binary count or a one-hot vector, chosen from the state count and a cutoff parameter. A pause option can be switched off. When it is off, the counter runs straight through the child windows, one state per cycle, and ignores child completion.

Top module: `ofs_sched_top`

## Requirements
- R1: After reset the block is idle. state_idx is 0, and child_en, first_st, final_st and done are all 0.
- R2: When start is high while the block is idle, the next cycle shows state_idx = 0 with first_st = 1.
- R3: In a normal state that is not the final state, state_idx increases by exactly 1 every cycle.
- R4: In the offload state of child k, child_en[k] is 1 and every other bit of child_en is 0. The state holds until child_done[k] is 1, and the following cycle shows the next state index.
- R5: With the default parameters (latency 100, windows [10,30) and [40,80)), child 0 offloads in state 10 and child 1 in state 21. There are 42 states in total, and final_st is 1 exactly in state 41.
- R6: child_done of a child has no effect on the state while the counter is not in that child's offload state.
- R7: Leaving the final state returns the counter to state 0 until REPEATS passes (default 2) have run.
- R8: done is a one-cycle pulse in the cycle after the final state of the last pass is left. In that same cycle the block is idle again.
- R9: start is ignored while the schedule is running.
- R10: When the state count is at or below ONE_HOT_CUTOFF the register is one-hot, and otherwise it is binary. A cutoff of 0 always gives binary. The port behaviour is identical under both encodings.
- R11: With PAUSE = 0 there are LATENCY states. child_en[k] is high in the states inside window k, and child_done is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | Launch the schedule when idle |
| child_done | input | NUM_CHILD | Completion from each child schedule |
| state_idx | output | SW | Current state as a binary index (0 when idle) |
| child_en | output | NUM_CHILD | Child k may run |
| first_st | output | 1 | Running and in state 0 |
| final_st | output | 1 | Running and in the last state |
| done | output | 1 | One-cycle pulse after the last pass |

## Verification
The hardest situations to reach are a child completion that arrives exactly in the final-state or offload cycle when the repeat count is also at its last pass, and a start pulse that coincides with the done cycle. The stimulus runs three phases. The first has sparse random child completions, which give long holds and many stray completions outside the offload states. The second has completions that are always high, so each offload lasts a single cycle. The third has dense start pulses, which produce starts during runs and on the done cycle. A behavioural model follows the binary instance, a one-hot instance and a non-pausing instance, and all three are compared with it every cycle.

// File: rtl/ofs_pkg.sv
// Shared helpers for the offload schedule counter.
// Assumes: nothing beyond IEEE 1800-2017 constant functions.
package ofs_pkg;

    // Bit width needed to index n states, never below one.
    function automatic int unsigned idx_width(int unsigned n);
        return (n < 2) ? 1 : $clog2(n);
    endfunction

endpackage

// File: rtl/ofs_state_reg.sv
// State register of the schedule counter, binary or one-hot.
// Presents the state as a binary index regardless of the storage chosen.
// Assumes: NSTATES >= 2; clear has priority over step.
module ofs_state_reg
    import ofs_pkg::*;
#(
    parameter int unsigned NSTATES = 42,
    parameter bit          ONEHOT  = 1'b0,
    localparam int unsigned SW     = idx_width(NSTATES)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          clear,
    input  logic          step,
    output logic [SW-1:0] idx
);

    generate
        if (ONEHOT) begin : g_onehot
            logic [NSTATES-1:0] vec_q;

            // Rotate the single hot bit forward, or park it on state 0.
            always_ff @(posedge clk) begin
                if (!rst_n)     vec_q <= NSTATES'(1);
                else if (clear) vec_q <= NSTATES'(1);
                else if (step)  vec_q <= {vec_q[NSTATES-2:0], 1'b0};
            end

            // Convert the hot position into a binary index.
            always_comb begin
                idx = '0;
                for (int i = 0; i < NSTATES; i++) begin
                    if (vec_q[i]) idx = idx | SW'(i);
                end
            end

            AST_ONEHOT_VALID: assert property (@(posedge clk) disable iff (!rst_n)
                $onehot(vec_q)); // R10
        end else begin : g_binary
            logic [SW-1:0] cnt_q;

            // Plain up-counter with synchronous clear.
            always_ff @(posedge clk) begin
                if (!rst_n)     cnt_q <= '0;
                else if (clear) cnt_q <= '0;
                else if (step)  cnt_q <= cnt_q + 1'b1;
            end

            assign idx = cnt_q;

            AST_BIN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
                cnt_q <= SW'(NSTATES - 1)); // R5
        end
    endgenerate

endmodule

// File: rtl/ofs_decode.sv
// Decodes the state index into child enables, first/final flags and the
// advance decision. With PAUSE each child owns one offload state that
// holds until its done; without PAUSE a child is enabled across its window.
// Assumes: windows sorted and non-overlapping, inside [0, LATENCY).
module ofs_decode
    import ofs_pkg::*;
#(
    parameter int unsigned NSTATES    = 42,
    parameter int unsigned NCHILD     = 2,
    parameter bit          PAUSE      = 1'b1,
    parameter int unsigned WIN_LO [NCHILD] = '{default: 0},
    parameter int unsigned WIN_HI [NCHILD] = '{default: 1},
    localparam int unsigned SW        = idx_width(NSTATES)
) (
    input  logic [SW-1:0]     idx,
    input  logic              busy,
    input  logic [NCHILD-1:0] child_done,
    output logic [NCHILD-1:0] child_en,
    output logic              first_st,
    output logic              final_st,
    output logic              adv
);

    // Offload state of child k: window start minus cycles already collapsed.
    function automatic int unsigned offload_state(int unsigned k);
        int unsigned gone = 0;
        for (int unsigned j = 0; j < k; j++) gone += WIN_HI[j] - WIN_LO[j];
        return WIN_LO[k] - gone + k;
    endfunction

    logic [NCHILD-1:0] hold;

    generate
        for (genvar k = 0; k < NCHILD; k++) begin : g_child
            if (PAUSE) begin : g_pause
                localparam int unsigned OFF = offload_state(k);
                // Enable on the single offload state; hold until child done.
                always_comb begin
                    child_en[k] = busy && (idx == SW'(OFF));
                    hold[k]     = child_en[k] && !child_done[k];
                end
            end else begin : g_count
                // Enable over the whole window; never hold.
                always_comb begin
                    child_en[k] = busy && (idx >= SW'(WIN_LO[k])) && (idx < SW'(WIN_HI[k]));
                    hold[k]     = 1'b0;
                end
            end
        end
    endgenerate

    // Boundary flags and the advance decision.
    always_comb begin
        first_st = busy && (idx == '0);
        final_st = busy && (idx == SW'(NSTATES - 1));
        adv      = busy && !(|hold);
    end

endmodule

// File: rtl/ofs_repeat.sv
// Counts the passes still to run after the current one.
// Assumes: REPEATS >= 1; load and dec never coincide.
module ofs_repeat
    import ofs_pkg::*;
#(
    parameter int unsigned REPEATS = 2,
    localparam int unsigned RW     = idx_width(REPEATS)
) (
    input  logic clk,
    input  logic rst_n,
    input  logic load,
    input  logic dec,
    output logic last
);

    logic [RW-1:0] left_q;

    // Load the remaining-pass count on launch, step down at each wrap.
    always_ff @(posedge clk) begin
        if (!rst_n)    left_q <= '0;
        else if (load) left_q <= RW'(REPEATS - 1);
        else if (dec)  left_q <= left_q - 1'b1;
    end

    assign last = (left_q == '0);

    AST_REP_NO_UNDERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
        dec |-> !last); // R7
    AST_REP_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        left_q <= RW'(REPEATS - 1)); // R7

endmodule

// File: rtl/ofs_sched_top.sv
// Schedule counter for a fixed-latency parent with child offload windows.
// Derives the state count from the windows, runs REPEATS passes per start
// and pulses done once after the last pass.
// Assumes: windows sorted, non-overlapping, within LATENCY; state count >= 2.
module ofs_sched_top
    import ofs_pkg::*;
#(
    parameter int unsigned LATENCY        = 100,
    parameter int unsigned NUM_CHILD      = 2,
    parameter int unsigned CHILD_BEG [NUM_CHILD] = '{10, 40},
    parameter int unsigned CHILD_END [NUM_CHILD] = '{30, 80},
    parameter int unsigned REPEATS        = 2,
    parameter int unsigned ONE_HOT_CUTOFF = 0,
    parameter bit          PAUSE          = 1'b1,
    localparam int unsigned NSTATES       = PAUSE ? ofs_count_states(NUM_CHILD) : LATENCY,
    localparam int unsigned SW            = idx_width(NSTATES)
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 start,
    input  logic [NUM_CHILD-1:0] child_done,
    output logic [SW-1:0]        state_idx,
    output logic [NUM_CHILD-1:0] child_en,
    output logic                 first_st,
    output logic                 final_st,
    output logic                 done
);

    // Gap cycles plus one offload state per child.
    function automatic int unsigned ofs_count_states(int unsigned n);
        int unsigned s = LATENCY;
        for (int unsigned k = 0; k < n; k++) s = s - (CHILD_END[k] - CHILD_BEG[k]) + 1;
        return s;
    endfunction

    localparam bit ONEHOT = (NSTATES <= ONE_HOT_CUTOFF);

    logic busy_q;
    logic done_q;
    logic adv;
    logic last;
    logic leave;

    assign leave = adv && final_st;

    ofs_state_reg #(
        .NSTATES (NSTATES),
        .ONEHOT  (ONEHOT)
    ) u_state (
        .clk   (clk),
        .rst_n (rst_n),
        .clear (!busy_q || leave),
        .step  (adv),
        .idx   (state_idx)
    );

    ofs_decode #(
        .NSTATES (NSTATES),
        .NCHILD  (NUM_CHILD),
        .PAUSE   (PAUSE),
        .WIN_LO  (CHILD_BEG),
        .WIN_HI  (CHILD_END)
    ) u_decode (
        .idx        (state_idx),
        .busy       (busy_q),
        .child_done (child_done),
        .child_en   (child_en),
        .first_st   (first_st),
        .final_st   (final_st),
        .adv        (adv)
    );

    ofs_repeat #(
        .REPEATS (REPEATS)
    ) u_repeat (
        .clk   (clk),
        .rst_n (rst_n),
        .load  (!busy_q && start),
        .dec   (leave && !last),
        .last  (last)
    );

    // Run/idle control and the completion pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy_q <= 1'b0;
            done_q <= 1'b0;
        end else begin
            busy_q <= busy_q ? !(leave && last) : start;
            done_q <= leave && last;
        end
    end

    assign done = done_q;

    AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done); // R8
    AST_DONE_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (child_en == '0) && !first_st && !final_st); // R8
    AST_NORMAL_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        busy_q && !(|child_en) && !final_st |=> state_idx == $past(state_idx) + 1'b1); // R3
    AST_WRAP_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        leave && !last |=> first_st); // R7
    AST_LAUNCH: assert property (@(posedge clk) disable iff (!rst_n)
        !busy_q && start |=> first_st); // R2
    AST_CHILD_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(child_en)); // R4

    generate
        if (PAUSE) begin : g_hold_chk
            for (genvar k = 0; k < NUM_CHILD; k++) begin : g_k
                AST_OFFLOAD_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
                    child_en[k] && !child_done[k] |=> child_en[k] && $stable(state_idx)); // R4
            end
        end
    endgenerate

endmodule

// File: tb/ofs_sched_top_tb_top.sv
// Bench: three instances (binary pausing, one-hot pausing, non-pausing)
// compared every cycle against behavioural models built from the requirements.
module ofs_sched_top_tb_top;

    localparam int CLK_PERIOD = 10;
    localparam int NCYC       = 3600;

    logic       clk = 1'b0;
    logic       rst_n;
    logic       start;
    logic [1:0] cdone;

    logic [5:0] b_state;  logic [1:0] b_en;  logic b_first, b_final, b_done;
    logic [5:0] h_state;  logic [1:0] h_en;  logic h_first, h_final, h_done;
    logic [6:0] n_state;  logic [1:0] n_en;  logic n_first, n_final, n_done;

    int total = 0;
    int bad   = 0;
    bit finished = 1'b0;

    always #(CLK_PERIOD / 2) clk = ~clk;

    ofs_sched_top dut_i (
        .clk(clk), .rst_n(rst_n), .start(start), .child_done(cdone),
        .state_idx(b_state), .child_en(b_en), .first_st(b_first),
        .final_st(b_final), .done(b_done));

    ofs_sched_top #(.ONE_HOT_CUTOFF(64)) dut_oh (
        .clk(clk), .rst_n(rst_n), .start(start), .child_done(cdone),
        .state_idx(h_state), .child_en(h_en), .first_st(h_first),
        .final_st(h_final), .done(h_done));

    ofs_sched_top #(.PAUSE(1'b0)) dut_np (
        .clk(clk), .rst_n(rst_n), .start(start), .child_done(cdone),
        .state_idx(n_state), .child_en(n_en), .first_st(n_first),
        .final_st(n_final), .done(n_done));

    // Pausing model (R5: offload states 10 and 21, final 41, 2 passes)
    int p_busy = 0, p_st = 0, p_rep = 0, p_done = 0;
    // Non-pausing model (R11: 100 states, windows [10,30) and [40,80))
    int q_busy = 0, q_st = 0, q_rep = 0, q_done = 0;

    task automatic chk(input string tag, input int act, input int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
        end
    endtask

    task automatic step_models();
        bit hold;
        p_done = 0;
        if (p_busy == 0) begin
            if (start) begin p_busy = 1; p_st = 0; p_rep = 1; end
        end else begin
            hold = (p_st == 10 && !cdone[0]) || (p_st == 21 && !cdone[1]);
            if (!hold) begin
                if (p_st == 41) begin
                    p_st = 0;
                    if (p_rep == 0) begin p_busy = 0; p_done = 1; end
                    else p_rep--;
                end else p_st++;
            end
        end
        q_done = 0;
        if (q_busy == 0) begin
            if (start) begin q_busy = 1; q_st = 0; q_rep = 1; end
        end else if (q_st == 99) begin
            q_st = 0;
            if (q_rep == 0) begin q_busy = 0; q_done = 1; end
            else q_rep--;
        end else q_st++;
    endtask

    task automatic compare_all();
        int pe0, pe1, qe0, qe1;
        pe0 = (p_busy != 0 && p_st == 10) ? 1 : 0;
        pe1 = (p_busy != 0 && p_st == 21) ? 1 : 0;
        chk("R2 R3 R5 R6 R9 state",    b_state, p_st);
        chk("R4 R6 child_en",          b_en, pe1 * 2 + pe0);
        chk("R2 first_st",             b_first, (p_busy != 0 && p_st == 0) ? 1 : 0);
        chk("R5 R7 final_st",          b_final, (p_busy != 0 && p_st == 41) ? 1 : 0);
        chk("R7 R8 done",              b_done, p_done);
        chk("R10 onehot state",        h_state, p_st);
        chk("R10 onehot child_en",     h_en, pe1 * 2 + pe0);
        chk("R10 onehot final/done",   h_final * 2 + h_done,
            ((p_busy != 0 && p_st == 41) ? 2 : 0) + p_done);
        qe0 = (q_busy != 0 && q_st >= 10 && q_st < 30) ? 1 : 0;
        qe1 = (q_busy != 0 && q_st >= 40 && q_st < 80) ? 1 : 0;
        chk("R11 nopause state",       n_state, q_st);
        chk("R11 nopause child_en",    n_en, qe1 * 2 + qe0);
        chk("R11 nopause final/done",  n_final * 2 + n_done,
            ((q_busy != 0 && q_st == 99) ? 2 : 0) + q_done);
    endtask

    initial begin
        rst_n = 1'b0;
        start = 1'b0;
        cdone = 2'b00;
        repeat (3) @(posedge clk);
        @(negedge clk);
        // R1: reset state on all outputs
        chk("R1 state",    b_state, 0);
        chk("R1 child_en", b_en, 0);
        chk("R1 first",    b_first, 0);
        chk("R1 final",    b_final, 0);
        chk("R1 done",     b_done, 0);
        chk("R1 nopause",  n_state + n_en + n_done, 0);
        rst_n = 1'b1;
        step_models();
        for (int i = 0; i < NCYC; i++) begin
            @(negedge clk);
            compare_all();
            if (i < 1500) begin
                // sparse completions: long holds, stray done (R6)
                start = ($urandom_range(0, 19) == 0);
                cdone = {($urandom_range(0, 5) == 0), ($urandom_range(0, 5) == 0)};
            end else if (i < 2500) begin
                // completions always high: one-cycle offload (R4)
                start = ($urandom_range(0, 9) == 0);
                cdone = 2'b11;
            end else begin
                // dense start while running and on done cycle (R9)
                start = ($urandom_range(0, 2) == 0);
                cdone = {($urandom_range(0, 39) == 0), ($urandom_range(0, 39) == 0)};
            end
            step_models();
        end
        finished = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            total++;
            bad++;
            $display("FAIL watchdog expired");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

endmodule